// File: doc/BRIEF.md
# Instrument status reporting unit

This block holds the status-reporting state of a measurement instrument and raises a level service request toward the system controller. Two event registers capture the start of internal conditions and keep each captured bit until the controller reads that register. An enable mask per register selects which captured bits feed that register's summary bit in the status byte. The status byte also carries an error-pending flag, a sequencing flag, a message-available flag for a one-entry output queue, and a request-service bit. A byte-wide service-request mask chooses which status-byte bits drive the request line.

The controller reaches everything through a simple register port. One strobe writes a mask and one strobe reads a register. The read data is registered and is valid one clock after the read strobe. Reading an event register clears it. A serial-poll read returns the status byte and clears the request-service bit. A separate output-form read returns the status byte with message-available forced to 1. Reading the queue address pops the queue entry.

Top module: `stat_report_unit`

## Requirements
- R1: After reset, all masks, event bits, the queue and the request-service bit are zero, `srq` is 0 and `reg_rdata` is 0.
- R2: An event bit is set on the clock edge where its condition input is first seen high after being low. It stays set until its register is read. The read returns it and clears it, and a condition that stays high does not set it again. The standard register is at address 3 and register B is at address 4.
- R3: When a condition rises in the same cycle as the read of its register, the read returns the value before that rise, and the bit is set after the read.
- R4: Status bit 5 is the OR of the standard event bits that are both set and enabled by the mask at address 1. Status bit 3 does the same for register B, using the mask at address 2.
- R5: `srq` is high, in the same cycle, whenever any status-byte bit except bit 6 is set and also set in the service-request mask at address 0. Writing 24 (0x18) enables only bits 3 and 4.
- R6: Writing any mask (addresses 0 to 2) leaves the event bits and the status condition bits unchanged.
- R7: The output queue holds one byte. A push replaces unread data, and status bit 4 is 1 while the queue holds data. A read of address 7 returns the byte and empties the queue, and it returns 0 when the queue is empty. A push in the same cycle as the pop is kept.
- R8: Status bit 2 follows `err_pending` and bit 1 follows `seq_flag`. Bits 0 and 7 always read 0.
- R9: A read of address 6 returns the status byte with bit 4 forced to 1, and it changes no state.
- R10: Status bit 6 sets on the cycle where the service-request condition becomes true. A serial-poll read of address 5 returns the status byte including bit 6 and clears only bit 6. A new rise in the same cycle wins over the clear.
- R11: Reads of addresses 0, 1 and 2 return the mask last written there, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Mask write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cond_std | input | EV_W | Condition inputs of the standard event register |
| cond_b | input | EVB_W | Condition inputs of event register B |
| err_pending | input | 1 | Error queue not empty |
| seq_flag | input | 1 | Test-sequence service flag |
| out_wr | input | 1 | Output queue push |
| out_data | input | 8 | Output queue data |
| srq | output | 1 | Level service request |

## Verification
`srq` is combinational from the stored state and the present `err_pending` and `seq_flag`. The bench therefore checks it 1 ns after it drives the inputs at the falling edge, within the same cycle. Event bits, the queue flag and the request-service bit change at the rising edge that samples the stimulus, so their effect appears in read data and in `srq` from the next falling edge. `reg_rdata` is registered on the edge that samples the read strobe, and the bench compares it at the following falling edge, before it drives the next operation. The bench model advances its state once per cycle in the same order, so every expected value is taken for the cycle in which it is due.

// File: rtl/stat_report_pkg.sv
package stat_report_pkg;
   localparam int unsigned STB_W = 8;

   typedef enum logic [2:0] {
      A_SRE  = 3'd0,
      A_ESE  = 3'd1,
      A_ESBE = 3'd2,
      A_ESR  = 3'd3,
      A_ESRB = 3'd4,
      A_POLL = 3'd5,
      A_STBO = 3'd6,
      A_OUTQ = 3'd7
   } reg_addr_e;

   localparam int unsigned BIT_SEQ  = 1;
   localparam int unsigned BIT_ERR  = 2;
   localparam int unsigned BIT_SUMB = 3;
   localparam int unsigned BIT_MAV  = 4;
   localparam int unsigned BIT_SUMS = 5;
   localparam int unsigned BIT_RQS  = 6;
endpackage

// File: rtl/stat_event_reg.sv
module stat_event_reg #(
   parameter int unsigned W         = 8,
   parameter bit          RISE_ONLY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic         mask_wr,
   input  logic [W-1:0] mask_wdata,
   input  logic         rd_clr,
   output logic [W-1:0] lat,
   output logic [W-1:0] mask,
   output logic         summary
);
   logic [W-1:0] hit;

   if (W < 1 || W > 8) begin : g_bad_w
      $error("stat_event_reg: W must be 1..8");
   end

   if (RISE_ONLY) begin : g_edge
      logic [W-1:0] cond_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cond_q <= '0;
         else        cond_q <= cond;
      end
      assign hit = cond & ~cond_q;
   end else begin : g_level
      assign hit = cond;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat  <= '0;
         mask <= '0;
      end else begin
         lat <= (lat & {W{~rd_clr}}) | hit;
         if (mask_wr) mask <= mask_wdata;
      end
   end

   assign summary = |(lat & mask);
endmodule

// File: rtl/stat_outq.sv
module stat_outq #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid
);
   logic [W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         valid  <= 1'b0;
      end else begin
         if (pop) valid <= 1'b0;
         if (push) begin
            valid  <= 1'b1;
            data_q <= din;
         end
      end
   end

   assign dout = valid ? data_q : '0;
endmodule

// File: rtl/stat_byte_sum.sv
module stat_byte_sum
   import stat_report_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sum_std,
   input  logic             sum_b,
   input  logic             mav,
   input  logic             err,
   input  logic             seq,
   input  logic             sre_wr,
   input  logic [STB_W-1:0] sre_wdata,
   input  logic             poll,
   output logic [STB_W-1:0] stb,
   output logic [STB_W-1:0] sre,
   output logic             srq,
   output logic             rqs
);
   localparam logic [STB_W-1:0] RQS_BIT = STB_W'(1) << BIT_RQS;

   logic [STB_W-1:0] cond_byte;
   logic             srq_q;

   always_comb begin
      cond_byte           = '0;
      cond_byte[BIT_SEQ]  = seq;
      cond_byte[BIT_ERR]  = err;
      cond_byte[BIT_SUMB] = sum_b;
      cond_byte[BIT_MAV]  = mav;
      cond_byte[BIT_SUMS] = sum_std;
   end

   assign srq = |(cond_byte & sre & ~RQS_BIT);
   assign stb = cond_byte | (rqs ? RQS_BIT : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sre   <= '0;
         rqs   <= 1'b0;
         srq_q <= 1'b0;
      end else begin
         if (sre_wr) sre <= sre_wdata;
         rqs   <= (rqs & ~poll) | (srq & ~srq_q);
         srq_q <= srq;
      end
   end
endmodule

// File: rtl/stat_report_unit.sv
module stat_report_unit
   import stat_report_pkg::*;
#(
   parameter int unsigned EV_W      = 8,
   parameter int unsigned EVB_W     = 8,
   parameter bit          RISE_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic [EV_W-1:0]  cond_std,
   input  logic [EVB_W-1:0] cond_b,
   input  logic             err_pending,
   input  logic             seq_flag,
   input  logic             out_wr,
   input  logic [7:0]       out_data,
   output logic             srq
);
   reg_addr_e        addr_e;
   logic [EV_W-1:0]  esr_lat, ese_mask;
   logic [EVB_W-1:0] esrb_lat, esbe_mask;
   logic             sum_std, sum_b, oq_valid, rqs_q;
   logic [7:0]       oq_dout, stb, sre, rd_mux;

   assign addr_e = reg_addr_e'(reg_addr);

   stat_event_reg #(.W(EV_W), .RISE_ONLY(RISE_ONLY)) u_std (
      .clk(clk), .rst_n(rst_n), .cond(cond_std),
      .mask_wr(reg_wr && addr_e == A_ESE), .mask_wdata(reg_wdata[EV_W-1:0]),
      .rd_clr(reg_rd && addr_e == A_ESR),
      .lat(esr_lat), .mask(ese_mask), .summary(sum_std));

   stat_event_reg #(.W(EVB_W), .RISE_ONLY(RISE_ONLY)) u_regb (
      .clk(clk), .rst_n(rst_n), .cond(cond_b),
      .mask_wr(reg_wr && addr_e == A_ESBE), .mask_wdata(reg_wdata[EVB_W-1:0]),
      .rd_clr(reg_rd && addr_e == A_ESRB),
      .lat(esrb_lat), .mask(esbe_mask), .summary(sum_b));

   stat_outq #(.W(8)) u_oq (
      .clk(clk), .rst_n(rst_n), .push(out_wr), .din(out_data),
      .pop(reg_rd && addr_e == A_OUTQ), .dout(oq_dout), .valid(oq_valid));

   stat_byte_sum u_sum (
      .clk(clk), .rst_n(rst_n), .sum_std(sum_std), .sum_b(sum_b),
      .mav(oq_valid), .err(err_pending), .seq(seq_flag),
      .sre_wr(reg_wr && addr_e == A_SRE), .sre_wdata(reg_wdata),
      .poll(reg_rd && addr_e == A_POLL),
      .stb(stb), .sre(sre), .srq(srq), .rqs(rqs_q));

   always_comb begin
      case (addr_e)
         A_SRE:   rd_mux = sre;
         A_ESE:   rd_mux = 8'(ese_mask);
         A_ESBE:  rd_mux = 8'(esbe_mask);
         A_ESR:   rd_mux = 8'(esr_lat);
         A_ESRB:  rd_mux = 8'(esrb_lat);
         A_POLL:  rd_mux = stb;
         A_STBO:  rd_mux = stb | (8'd1 << BIT_MAV);
         A_OUTQ:  rd_mux = oq_dout;
         default: rd_mux = 8'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= 8'd0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end
endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk #(
   parameter int unsigned EV_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_rd,
   input logic            reg_wr,
   input logic [2:0]      reg_addr,
   input logic [EV_W-1:0] cond_std,
   input logic            out_wr,
   input logic            srq,
   input logic [EV_W-1:0] esr_lat,
   input logic            oq_valid,
   input logic            rqs_q
);
   AST_EVT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd3) |=> (esr_lat == ($past(cond_std) & ~$past(cond_std, 2)))); // R3
   AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == 3'd3) |=> ((esr_lat & $past(esr_lat)) == $past(esr_lat))); // R2
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr <= 3'd2 && !reg_rd) |=>
         (esr_lat == ($past(esr_lat) | ($past(cond_std) & ~$past(cond_std, 2))))); // R6
   AST_OQ_MAV: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> oq_valid); // R7
   AST_RQS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd5 && !srq) |=> !rqs_q); // R10
endmodule

bind stat_report_unit stat_report_chk #(.EV_W(EV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .cond_std(cond_std), .out_wr(out_wr), .srq(srq), .esr_lat(esr_lat),
   .oq_valid(oq_valid), .rqs_q(rqs_q));

// File: tb/sim_stat_report_unit.sv
module sim_stat_report_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [7:0] cond_std = 8'd0, cond_b = 8'd0;
   logic       err_pending = 1'b0, seq_flag = 1'b0;
   logic       out_wr = 1'b0;
   logic [7:0] out_data = 8'd0;
   logic       srq;

   int unsigned n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   // bench-side inputs and requirement model
   logic [7:0] cs = 0, cb = 0;
   bit         er = 0, sq = 0;
   logic [7:0] m_sre = 0, m_ese = 0, m_esbe = 0, m_esr = 0, m_esrb = 0;
   logic [7:0] m_cp = 0, m_cbp = 0, m_oqd = 0;
   bit         m_oqv = 0, m_rqs = 0, m_srqp = 0;
   bit         pend = 0;
   logic [7:0] pend_exp = 0;
   string      pend_tag = "";

   stat_report_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_std(cond_std), .cond_b(cond_b),
      .err_pending(err_pending), .seq_flag(seq_flag), .out_wr(out_wr),
      .out_data(out_data), .srq(srq));

   always #5 clk = ~clk;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // R4, R8: status byte without bit 6
   function automatic logic [7:0] m_stb();
      logic [7:0] b = 8'd0;
      b[1] = sq;
      b[2] = er;
      b[3] = |(m_esr == m_esr ? (m_esrb & m_esbe) : 8'd0);
      b[4] = m_oqv;
      b[5] = |(m_esr & m_ese);
      return b;
   endfunction

   function automatic string tag_of(logic [2:0] a);
      case (a)
         3'd0, 3'd1, 3'd2: return "R11";
         3'd3, 3'd4:       return "R2";
         3'd5:             return "R10";
         3'd6:             return "R9";
         default:          return "R7";
      endcase
   endfunction

   task automatic cyc(bit rd, bit wr, logic [2:0] a, logic [7:0] wd, bit push, logic [7:0] pd);
      logic [7:0] stb, rise, riseb;
      bit         srq_e;
      @(negedge clk);
      if (pend) chk(pend_tag, reg_rdata, pend_exp);
      reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      out_wr = push; out_data = pd;
      cond_std = cs; cond_b = cb; err_pending = er; seq_flag = sq;
      #1;
      stb   = m_stb();
      srq_e = |(stb & m_sre & 8'hBF);
      chk("R5", {7'd0, srq}, {7'd0, srq_e});
      pend = rd;
      if (rd) begin
         pend_tag = tag_of(a);
         case (a)
            3'd0: pend_exp = m_sre;
            3'd1: pend_exp = m_ese;
            3'd2: pend_exp = m_esbe;
            3'd3: pend_exp = m_esr;
            3'd4: pend_exp = m_esrb;
            3'd5: pend_exp = stb | (m_rqs ? 8'h40 : 8'h00);
            3'd6: pend_exp = stb | (m_rqs ? 8'h40 : 8'h00) | 8'h10;
            default: pend_exp = m_oqv ? m_oqd : 8'h00;
         endcase
      end
      rise  = cs & ~m_cp;
      riseb = cb & ~m_cbp;
      m_esr  = ((rd && a == 3'd3) ? 8'd0 : m_esr) | rise;
      m_esrb = ((rd && a == 3'd4) ? 8'd0 : m_esrb) | riseb;
      m_cp = cs; m_cbp = cb;
      if (wr) begin
         if (a == 3'd0) m_sre = wd;
         if (a == 3'd1) m_ese = wd;
         if (a == 3'd2) m_esbe = wd;
      end
      if (rd && a == 3'd7) m_oqv = 0;
      if (push) begin m_oqv = 1; m_oqd = pd; end
      m_rqs  = (m_rqs & !(rd && a == 3'd5)) | (srq_e & !m_srqp);
      m_srqp = srq_e;
   endtask

   task automatic idle();
      cyc(0, 0, 3'd0, 8'd0, 0, 8'd0);
   endtask

   task automatic rd_lit(logic [2:0] a, logic [7:0] exp, string tag);
      cyc(1, 0, a, 8'd0, 0, 8'd0);
      idle();
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d);
      cyc(0, 1, a, d, 0, 8'd0);
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      chk("R1", {7'd0, srq}, 8'd0);
      chk("R1", reg_rdata, 8'd0);
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 8; a++) rd_lit(3'(a), (a == 6) ? 8'h10 : 8'h00, "R1");

      // R2: latch on rise, held condition does not re-latch
      cs = 8'h01; idle(); idle();
      rd_lit(3'd3, 8'h01, "R2");
      rd_lit(3'd3, 8'h00, "R2");
      // R3: rise in the read cycle survives the clear
      cs = 8'h03;
      rd_lit(3'd3, 8'h00, "R3");
      rd_lit(3'd3, 8'h02, "R3");
      cs = 8'h00; idle();

      // R5: mask 24 enables bits 3 and 4 only
      wr_reg(3'd0, 8'd24);
      er = 1; sq = 1; idle();
      chk("R5", {7'd0, srq}, 8'd0);
      cyc(0, 0, 3'd0, 8'd0, 1, 8'hA5);
      idle();
      chk("R5", {7'd0, srq}, 8'd1);
      // R7: overwrite, pop, empty pop
      cyc(0, 0, 3'd0, 8'd0, 1, 8'h3C);
      rd_lit(3'd7, 8'h3C, "R7");
      chk("R5", {7'd0, srq}, 8'd0);
      rd_lit(3'd7, 8'h00, "R7");
      // R10, R8: poll shows bit 6, then clears it
      rd_lit(3'd5, 8'h46, "R10");
      rd_lit(3'd5, 8'h06, "R8");
      er = 0; sq = 0;
      // R9
      rd_lit(3'd6, 8'h10, "R9");

      // R6, R4: mask writes keep latched bits; summary bits follow masks
      cb = 8'h80; cs = 8'h04; idle();
      wr_reg(3'd1, 8'hFF); wr_reg(3'd0, 8'h28); wr_reg(3'd2, 8'h80);
      chk("R4", {7'd0, srq}, 8'd1);
      rd_lit(3'd5, 8'h68, "R4");
      rd_lit(3'd3, 8'h04, "R6");
      rd_lit(3'd4, 8'h80, "R6");
      rd_lit(3'd1, 8'hFF, "R11");
      cs = 0; cb = 0; idle();

      for (int i = 0; i < 4000; i++) begin
         int unsigned op = $urandom % 10;
         logic [2:0]  a  = 3'($urandom % 8);
         if ($urandom % 6 == 0) cs = cs ^ (8'd1 << ($urandom % 8));
         if ($urandom % 6 == 0) cb = cb ^ (8'd1 << ($urandom % 8));
         if ($urandom % 20 == 0) er = !er;
         if ($urandom % 25 == 0) sq = !sq;
         cyc(op < 4, op >= 4 && op < 6, (op >= 4 && op < 6) ? 3'(a % 3) : a,
             8'($urandom), ($urandom % 5) == 0, 8'($urandom));
      end
      idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule